// File: doc/BRIEF.md
# Segmented transposed PN correlator for code acquisition

This block builds the delay profile used to acquire a spreading code. A stream of signed baseband samples, taken at two samples per chip, is correlated against a locally held PN code. Each profile entry is the correlation at one half-chip lag. The filter holds only one segment of the code at a time, `SEG_TAPS` chips. The profile is built over several passes, one pass per code segment. Each pass adds its partial correlation into a profile memory indexed by lag. After the last segment, every entry equals what a correlator holding the whole code in parallel would give.

The datapath is transposed. Every accepted sample is multiplied by all tap coefficients in the same cycle. The products are folded into a chain of registered partial sums, with `SPC` registers between adjacent taps. The newest sample meets the highest tap last, directly at the chain end, so no adder tree spans all taps. Code bits arrive serially into a shadow register. Each tap copies its shadow bit at its own moment in the pass: tap 0 first, then the higher taps in turn. This allows the next segment to be shifted in while the current pass finishes. For segment `s`, the caller streams samples starting at sample index `SPC*SEG_TAPS*s`.

Top module: `pn_seg_mf`

## Requirements
- R1: A synchronous active-high `rst` clears the chain, the taps, the profile memory and the pass state. `prof_vld` is low after reset. A pass started with `seg_first` low right after reset yields just that segment's partial sums.
- R2: A code bit of 0 stands for +1 and a bit of 1 stands for -1. Of the `SEG_TAPS` bits shifted in for a segment, the first received belongs to the lowest chip index of that segment.
- R3: A `seg_start` pulse begins a pass. The first `SPC*(SEG_TAPS-1)` accepted samples produce no output. Each of the next `LAGS` accepted samples produces one output, with `prof_lag` counting up from 0. The output appears two clock edges after the sample is accepted.
- R4: The partial value of a pass at lag `m` is the sum over k of `c[k]·x[m+SPC·k]`, where `x` counts the samples of the pass and `c[k]` is the sign of tap k.
- R5: A pass started with `seg_first` high writes its partial sums into the profile, replacing the old contents. Otherwise it adds them to the stored values. After all `NUM_SEGS` segments, `prof_val` equals the full-length correlation at that lag.
- R6: Cycles with `smp_vld` low have no effect. Gaps inside a pass leave the results unchanged.
- R7: Samples are ignored when no pass is open, after a pass has produced its `LAGS` outputs, or in the cycle of `seg_start`.
- R8: Tap k takes its new coefficient from the shadow register when pass sample `k·SPC` is accepted, and uses it for that sample. Shifting in the next segment's code from pass sample `SPC*(SEG_TAPS-1)` on does not disturb the current pass.
- R9: Values are `SMP_W+1+clog2(SEG_TAPS·NUM_SEGS)` bits wide. This holds a full-scale negative sample negated at every tap without overflow.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| code_bit | input | 1 | Serial PN code bit (0 = +1, 1 = -1) |
| code_vld | input | 1 | Shifts `code_bit` into the shadow register |
| seg_start | input | 1 | Opens a new pass |
| seg_first | input | 1 | With `seg_start`: the pass replaces rather than adds |
| smp_vld | input | 1 | Sample strobe |
| smp_in | input | SMP_W | Signed sample |
| prof_vld | output | 1 | Profile update strobe |
| prof_lag | output | clog2(LAGS) | Half-chip lag of the update |
| prof_val | output | ACC_W | Signed accumulated correlation at that lag |

## Verification
The bench builds the block with three taps per segment, three segments, two samples per chip and six lags. With these values a whole nine-chip profile fits in 22 samples. This small build still reaches the fill phase, the hand-over between segments, staggered loads overlapping the next code shift, and the end-of-window cut-off. The bench also runs full-scale negative samples against an all-minus code to exercise the negate of the most negative value.

// File: rtl/pn_seg_mf_pkg.sv
package pn_seg_mf_pkg;

    // Width that holds the worst-case full-length correlation
    function automatic int acc_bits(input int smp_w, input int code_len);
        return smp_w + 1 + $clog2(code_len);
    endfunction

    function automatic int idx_bits(input int n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction

    // Control tag that travels with a section result
    typedef struct packed {
        logic vld;
        logic first;
    } sec_tag_t;

endpackage

// File: rtl/pn_seg_mf_seq.sv
module pn_seg_mf_seq #(
    parameter int N     = 16,
    parameter int SPC   = 2,
    parameter int LAGS  = 64,
    parameter int LAG_W = 6
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             code_bit,
    input  logic             code_vld,
    input  logic             seg_start,
    input  logic             seg_first,
    input  logic             smp_vld,
    output logic             smp_acc,
    output logic             pass_act,
    output logic             pass_first,
    output logic [N-1:0]     shadow,
    output logic [N-1:0]     ld_en,
    output logic             emit,
    output logic [LAG_W-1:0] emit_lag
);
    localparam int FILL  = SPC * (N - 1);
    localparam int TOTAL = FILL + LAGS;
    localparam int CNT_W = $clog2(TOTAL + 1);

    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] lag_full;

    assign smp_acc  = smp_vld && pass_act && !seg_start;
    assign emit     = smp_acc && (cnt >= CNT_W'(FILL));
    assign lag_full = cnt - CNT_W'(FILL);
    assign emit_lag = lag_full[LAG_W-1:0];

    // Staggered per-tap load strobes: tap k on pass sample k*SPC
    for (genvar k = 0; k < N; k++) begin : g_ld
        assign ld_en[k] = smp_acc && (cnt == CNT_W'(k * SPC));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pass_act   <= 1'b0;
            pass_first <= 1'b0;
            cnt        <= '0;
            shadow     <= '0;
        end else begin
            if (code_vld) begin
                shadow <= {code_bit, shadow[N-1:1]};
            end
            if (seg_start) begin
                pass_act   <= 1'b1;
                pass_first <= seg_first;
                cnt        <= '0;
            end else if (smp_acc) begin
                cnt <= cnt + 1'b1;
                if (cnt == CNT_W'(TOTAL - 1)) begin
                    pass_act <= 1'b0;
                end
            end
        end
    end
endmodule

// File: rtl/pn_seg_mf_chain.sv
module pn_seg_mf_chain #(
    parameter int SMP_W = 8,
    parameter int N     = 16,
    parameter int SPC   = 2,
    parameter int ACC_W = 16
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    smp_acc,
    input  logic signed [SMP_W-1:0] smp_in,
    input  logic [N-1:0]            shadow,
    input  logic [N-1:0]            ld_en,
    output logic signed [ACC_W-1:0] sec
);
    localparam int DEPTH = SPC * (N - 1);

    logic [N-1:0]            tap_q;
    logic [N-1:0]            coef;
    logic signed [ACC_W-1:0] ext;
    logic signed [ACC_W-1:0] prod [N];
    logic signed [ACC_W-1:0] part [DEPTH];

    assign ext  = {{(ACC_W - SMP_W){smp_in[SMP_W-1]}}, smp_in};
    // A tap being loaded this cycle already applies its new bit
    assign coef = (ld_en & shadow) | (~ld_en & tap_q);

    for (genvar k = 0; k < N; k++) begin : g_mul
        assign prod[k] = coef[k] ? -ext : ext;
    end

    // Highest tap joins at the chain end, with no register
    assign sec = part[DEPTH-1] + prod[N-1];

    always_ff @(posedge clk) begin
        if (rst) begin
            tap_q <= '0;
            for (int i = 0; i < DEPTH; i++) part[i] <= '0;
        end else begin
            tap_q <= coef;
            if (smp_acc) begin
                part[0] <= prod[0];
                for (int i = 1; i < DEPTH; i++) begin
                    part[i] <= (i % SPC == 0) ? part[i-1] + prod[i/SPC] : part[i-1];
                end
            end
        end
    end
endmodule

// File: rtl/pn_seg_mf_accum.sv
module pn_seg_mf_accum #(
    parameter int LAGS  = 64,
    parameter int LAG_W = 6,
    parameter int ACC_W = 16
) (
    input  logic                       clk,
    input  logic                       rst,
    input  pn_seg_mf_pkg::sec_tag_t    tag,
    input  logic [LAG_W-1:0]           lag,
    input  logic signed [ACC_W-1:0]    val,
    output logic                       prof_vld,
    output logic [LAG_W-1:0]           prof_lag,
    output logic signed [ACC_W-1:0]    prof_val
);
    logic signed [ACC_W-1:0] mem [LAGS];
    logic signed [ACC_W-1:0] base;
    logic signed [ACC_W-1:0] sum;

    assign base = tag.first ? '0 : mem[lag];
    assign sum  = base + val;

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < LAGS; i++) mem[i] <= '0;
            prof_vld <= 1'b0;
            prof_lag <= '0;
            prof_val <= '0;
        end else begin
            prof_vld <= tag.vld;
            if (tag.vld) begin
                mem[lag] <= sum;
                prof_lag <= lag;
                prof_val <= sum;
            end
        end
    end
endmodule

// File: rtl/pn_seg_mf.sv
module pn_seg_mf
    import pn_seg_mf_pkg::*;
#(
    parameter  int SMP_W    = 8,
    parameter  int SEG_TAPS = 16,
    parameter  int NUM_SEGS = 8,
    parameter  int SPC      = 2,
    parameter  int LAGS     = 64,
    localparam int CODE_LEN = SEG_TAPS * NUM_SEGS,
    localparam int ACC_W    = acc_bits(SMP_W, CODE_LEN),
    localparam int LAG_W    = idx_bits(LAGS)
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    code_bit,
    input  logic                    code_vld,
    input  logic                    seg_start,
    input  logic                    seg_first,
    input  logic                    smp_vld,
    input  logic signed [SMP_W-1:0] smp_in,
    output logic                    prof_vld,
    output logic [LAG_W-1:0]        prof_lag,
    output logic signed [ACC_W-1:0] prof_val
);
    logic                    smp_acc;
    logic                    pass_act;
    logic                    pass_first;
    logic [SEG_TAPS-1:0]     shadow;
    logic [SEG_TAPS-1:0]     ld_en;
    logic                    emit;
    logic [LAG_W-1:0]        emit_lag;
    logic signed [ACC_W-1:0] sec;

    sec_tag_t                tag_q;
    logic [LAG_W-1:0]        lag_q;
    logic signed [ACC_W-1:0] sec_q;

    pn_seg_mf_seq #(.N(SEG_TAPS), .SPC(SPC), .LAGS(LAGS), .LAG_W(LAG_W)) u_seq (
        .clk(clk), .rst(rst), .code_bit(code_bit), .code_vld(code_vld),
        .seg_start(seg_start), .seg_first(seg_first), .smp_vld(smp_vld),
        .smp_acc(smp_acc), .pass_act(pass_act), .pass_first(pass_first),
        .shadow(shadow), .ld_en(ld_en), .emit(emit), .emit_lag(emit_lag)
    );

    pn_seg_mf_chain #(.SMP_W(SMP_W), .N(SEG_TAPS), .SPC(SPC), .ACC_W(ACC_W)) u_chain (
        .clk(clk), .rst(rst), .smp_acc(smp_acc), .smp_in(smp_in),
        .shadow(shadow), .ld_en(ld_en), .sec(sec)
    );

    // Section result register between the chain and the profile memory
    always_ff @(posedge clk) begin
        if (rst) begin
            tag_q <= '0;
            lag_q <= '0;
            sec_q <= '0;
        end else begin
            tag_q.vld   <= emit;
            tag_q.first <= pass_first;
            lag_q       <= emit_lag;
            sec_q       <= sec;
        end
    end

    pn_seg_mf_accum #(.LAGS(LAGS), .LAG_W(LAG_W), .ACC_W(ACC_W)) u_acc (
        .clk(clk), .rst(rst), .tag(tag_q), .lag(lag_q), .val(sec_q),
        .prof_vld(prof_vld), .prof_lag(prof_lag), .prof_val(prof_val)
    );
endmodule

// File: rtl/pn_seg_mf_chk.sv
module pn_seg_mf_chk #(
    parameter int N     = 16,
    parameter int LAGS  = 64,
    parameter int LAG_W = 6
) (
    input logic             clk,
    input logic             rst,
    input logic             smp_vld,
    input logic             seg_start,
    input logic             pass_act,
    input logic [N-1:0]     ld_en,
    input logic             prof_vld,
    input logic [LAG_W-1:0] prof_lag
);
    // R3
    out_needs_sample_chk: assert property (@(posedge clk) disable iff (rst)
        prof_vld |-> $past(smp_vld, 2));

    // R3
    lag_step_chk: assert property (@(posedge clk) disable iff (rst)
        (prof_vld && $past(prof_vld)) |-> (prof_lag == LAG_W'($past(prof_lag) + 1'b1)));

    // R3
    lag_range_chk: assert property (@(posedge clk) disable iff (rst)
        prof_vld |-> (int'(prof_lag) < LAGS));

    // R8
    one_load_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0(ld_en));

    // R7
    idle_drop_chk: assert property (@(posedge clk) disable iff (rst)
        (smp_vld && (!pass_act || seg_start)) |=> ##1 !prof_vld);
endmodule

bind pn_seg_mf pn_seg_mf_chk #(.N(SEG_TAPS), .LAGS(LAGS), .LAG_W(LAG_W)) u_chk (
    .clk(clk), .rst(rst), .smp_vld(smp_vld), .seg_start(seg_start),
    .pass_act(pass_act), .ld_en(ld_en), .prof_vld(prof_vld), .prof_lag(prof_lag)
);

// File: tb/pn_seg_mf_test.sv
module pn_seg_mf_test;
    localparam int SMP_W = 8;
    localparam int N     = 3;
    localparam int NS    = 3;
    localparam int SPC   = 2;
    localparam int LAGS  = 6;
    localparam int L     = N * NS;
    localparam int FILL  = SPC * (N - 1);
    localparam int PASS  = FILL + LAGS;
    localparam int XLEN  = LAGS + SPC * (L - 1);
    localparam int ACC_W = SMP_W + 1 + $clog2(L);
    localparam int LAG_W = $clog2(LAGS);

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic code_bit = 1'b0, code_vld = 1'b0, seg_start = 1'b0, seg_first = 1'b0;
    logic smp_vld = 1'b0;
    logic signed [SMP_W-1:0] smp_in = '0;
    logic prof_vld;
    logic [LAG_W-1:0] prof_lag;
    logic signed [ACC_W-1:0] prof_val;

    int tests_run = 0, tests_failed = 0;
    bit done = 1'b0;
    int xs [XLEN];
    bit cs [L];
    int got [LAGS];
    int got_n = 0, next_lag = 0, order_err = 0;

    always #5 clk = ~clk;

    pn_seg_mf #(.SMP_W(SMP_W), .SEG_TAPS(N), .NUM_SEGS(NS), .SPC(SPC), .LAGS(LAGS)) uut (
        .clk(clk), .rst(rst), .code_bit(code_bit), .code_vld(code_vld),
        .seg_start(seg_start), .seg_first(seg_first), .smp_vld(smp_vld),
        .smp_in(smp_in), .prof_vld(prof_vld), .prof_lag(prof_lag), .prof_val(prof_val)
    );

    always @(negedge clk) begin
        if (prof_vld) begin
            got[prof_lag] = int'(prof_val);
            if (int'(prof_lag) != next_lag) order_err++;
            next_lag++;
            got_n++;
        end
    end

    task automatic chk(input int act, input int exp, input string req);
        tests_run++;
        if (act != exp) begin
            tests_failed++;
            $display("FAIL %s: got %0d expected %0d", req, act, exp);
        end
    endtask

    // R4 R2: expected sum over chips jlo..jhi-1, bit 1 meaning -1
    function automatic int expect_sum(input int lag, input int jlo, input int jhi);
        int s = 0;
        for (int j = jlo; j < jhi; j++) s += (cs[j] ? -1 : 1) * xs[lag + SPC * j];
        return s;
    endfunction

    task automatic load_seg(input int s);
        for (int k = 0; k < N; k++) begin
            @(negedge clk); code_bit = cs[s * N + k]; code_vld = 1'b1;
        end
        @(negedge clk); code_vld = 1'b0;
    endtask

    // One pass over segment s; optional gaps and overlapped loading of segment s+1
    task automatic run_pass(input int s, input bit first, input bit gaps, input bit overlap);
        int kbit = 0;
        got_n = 0; next_lag = 0; order_err = 0;
        @(negedge clk); seg_start = 1'b1; seg_first = first;
        smp_vld = 1'b1; smp_in = 8'sd99;       // R7: ignored in the start cycle
        @(negedge clk); seg_start = 1'b0; seg_first = 1'b0;
        for (int i = 0; i < PASS; i++) begin
            smp_vld = 1'b1;
            smp_in  = SMP_W'(xs[SPC * s * N + i]);
            if (overlap && i >= FILL && kbit < N) begin
                code_bit = cs[(s + 1) * N + kbit]; code_vld = 1'b1; kbit++;
            end else code_vld = 1'b0;
            @(negedge clk);
            code_vld = 1'b0;
            if (gaps && (i % 2 == 1)) begin
                smp_vld = 1'b0; smp_in = 8'sd77;  // R6: must not count
                @(negedge clk);
            end
        end
        smp_vld = 1'b0;
        while (overlap && kbit < N) begin
            code_bit = cs[(s + 1) * N + kbit]; code_vld = 1'b1; kbit++;
            @(negedge clk);
        end
        code_vld = 1'b0;
        repeat (3) @(negedge clk);
        chk(got_n, LAGS, "R3 output count");
        chk(order_err, 0, "R3 lag order");
    endtask

    task automatic check_prof(input int jlo, input int jhi, input string req);
        for (int m = 0; m < LAGS; m++) chk(got[m], expect_sum(m, jlo, jhi), req);
    endtask

    task automatic do_reset();
        rst = 1'b1;
        repeat (2) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
    endtask

    // R1: reset state, samples with no pass open, memory cleared
    task automatic t_reset();
        for (int i = 0; i < XLEN; i++) xs[i] = i - 7;
        for (int j = 0; j < L; j++) cs[j] = (j % 3 == 1);
        do_reset();
        chk(int'(prof_vld), 0, "R1 prof_vld after reset");
        got_n = 0;
        for (int i = 0; i < 5; i++) begin
            @(negedge clk); smp_vld = 1'b1; smp_in = 8'sd50;
        end
        @(negedge clk); smp_vld = 1'b0;
        repeat (3) @(negedge clk);
        chk(got_n, 0, "R7 no pass open");
        load_seg(1);
        run_pass(1, 1'b0, 1'b0, 1'b0);
        check_prof(N, 2 * N, "R1 cleared memory");
    endtask

    // R2 R4 R5: full run, segment by segment
    task automatic t_full(input bit gaps, input int seed);
        for (int i = 0; i < XLEN; i++) xs[i] = ((i * 37 + seed) % 200) - 100;
        for (int j = 0; j < L; j++) cs[j] = ((j * 5 + seed) % 7) < 3;
        for (int s = 0; s < NS; s++) begin
            load_seg(s);
            run_pass(s, s == 0, gaps, 1'b0);
            check_prof(0, (s + 1) * N, gaps ? "R6 gaps partial" : "R5 partial");
        end
        check_prof(0, L, "R5 full correlation");
    endtask

    // R8: next code shifted while the current pass finishes
    task automatic t_overlap();
        for (int i = 0; i < XLEN; i++) xs[i] = ((i * 53 + 3) % 230) - 115;
        for (int j = 0; j < L; j++) cs[j] = (j % 2 == 0) ^ (j > 5);
        load_seg(0);
        for (int s = 0; s < NS; s++) begin
            run_pass(s, s == 0, 1'b0, s < NS - 1);
            check_prof(0, (s + 1) * N, "R8 overlapped load");
        end
    endtask

    // R7: samples after the window are dropped
    task automatic t_tail();
        got_n = 0;
        for (int i = 0; i < 4; i++) begin
            @(negedge clk); smp_vld = 1'b1; smp_in = 8'sd120;
        end
        @(negedge clk); smp_vld = 1'b0;
        repeat (3) @(negedge clk);
        chk(got_n, 0, "R7 past window");
    endtask

    // R9: full-scale negative samples against an all-minus code
    task automatic t_extreme();
        for (int i = 0; i < XLEN; i++) xs[i] = -128;
        for (int j = 0; j < L; j++) cs[j] = 1'b1;
        for (int s = 0; s < NS; s++) begin
            load_seg(s);
            run_pass(s, s == 0, 1'b0, 1'b0);
        end
        for (int m = 0; m < LAGS; m++) chk(got[m], 128 * L, "R9 full scale");
    endtask

    initial begin
        t_reset();
        t_full(1'b0, 11);
        t_full(1'b1, 4);
        t_overlap();
        t_tail();
        t_extreme();
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", tests_run, tests_failed);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            tests_run++;
            tests_failed++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", tests_run, tests_failed);
            $finish;
        end
    end
endmodule